// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Mask, Pending and In-Service Tracking

This block gathers interrupt requests from a set of on-chip sources (one of them the completion request of a DMA channel) and from a few active-low external pins, and reduces them to a single prioritized request for a processor core. Every on-chip source requests at one shared fixed level. Each external pin has its own fixed level set by a parameter. Software sees four registers through a simple register port: an enable (mask) register, a pending register, an in-service register, and a mode register. The mode register also reports the external pending bits.

The core supplies its current run level and a strobe at each instruction boundary. When the strongest enabled request is above the run level and the strobe is seen, the controller acknowledges it. In the following cycle it presents a one-cycle acknowledge with the request's level and a source vector. In the same clock edge it moves an on-chip source from pending to in-service, or clears an edge-mode pin's pending bit. Software ends the service of an on-chip source by writing a one to its in-service bit.

Top module: `prio_irq_ctl`

## Requirements
- R1: An acknowledge is taken only on a clock edge where `instr_end` is high and the winning level is strictly greater than `run_level`. `ack_valid` is then high for exactly the following cycle and carries `ack_vector` and `ack_level`. At any other time `ack_valid` stays low.
- R2: Every on-chip source requests at level `INT_LEVEL` (default 4). `irq_level` shows the winning level when that level is above `run_level`, and shows 0 otherwise.
- R3: Mask register (address 0): a one in bit j lets on-chip source j compete, and a zero keeps it out. Its pending bit is still recorded while it is masked.
- R4: Pending register (address 1, read-only): bit j is set on any clock edge where `int_req[j]` is high. It stays set until source j is acknowledged, and is then cleared on that acknowledge edge.
- R5: Among eligible on-chip sources, the highest bit number wins. Its vector is `VEC_BASE + j` (default base 0x40).
- R6: An acknowledge of on-chip source j sets in-service bit j (address 2). While any in-service bit at index j or above is set, source j is not eligible. A source with a higher index stays eligible.
- R7: Writing the in-service register clears each bit written as one and leaves each bit written as zero unchanged. If the same bit is acknowledged on that edge, the set wins.
- R8: Mode register (address 3): bit k = 1 puts external pin k in edge mode. A falling edge of `ext_irq_n[k]` sets its pending bit, and an acknowledge of pin k clears it. Holding the pin low does not set it again. The pin's vector is `VEC_BASE + N_INT + k` (default 0x50 + k).
- R9: With mode bit k = 0 (level mode), the pending bit of pin k is the inverted pin, registered one cycle. An acknowledge does not clear it.
- R10: The highest level wins. At equal level an external pin beats the on-chip group, and a higher pin index beats a lower one. Default pin levels are 1, 4 and 7 for pins 0, 1 and 2. A read of address 3 returns the mode bits in [N_EXT-1:0] and the external pending bits in [2*N_EXT-1:N_EXT].
- R11: The DMA channel's completion request is `int_req[11]`. Mask bit 11 alone enables it, and it is arbitrated like any other on-chip source.
- R12: After a synchronous active-low reset, all four registers read 0, `ack_valid` is low and `irq_level` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| int_req | input | N_INT | On-chip source request lines |
| ext_irq_n | input | N_EXT | Active-low external interrupt pins |
| run_level | input | 3 | Current processor run level |
| instr_end | input | 1 | Instruction-boundary strobe |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | N_INT | Register write data |
| reg_rdata | output | N_INT | Register read data (combinational) |
| irq_level | output | 3 | Level of the request presented to the core |
| ack_valid | output | 1 | One-cycle acknowledge |
| ack_vector | output | 8 | Vector of the acknowledged source |
| ack_level | output | 3 | Level of the acknowledged source |

## Verification
An acknowledge that sets an in-service bit can land on the same edge as a software write that clears in-service bits. The bench provokes this by raising `instr_end` while a write to address 2 clears both a stale bit and the bit being acknowledged. It then judges the result by reading address 2: the stale bit must be gone and the acknowledged bit must be set. A table of mask, request and run-level rows covers arbitration. Directed cases cover blocking by in-service bits, edge and level external pins, and ties between a pin and the on-chip group.

// File: rtl/irq_ctl_pkg.sv
// Shared definitions for the prioritized interrupt controller.
// Assumes a 3-bit level code, where level 0 means "no request".
package irq_ctl_pkg;

    localparam int LVL_W = 3;

    // Register select codes on the register port.
    typedef enum logic [1:0] {
        SEL_MASK  = 2'd0,
        SEL_PEND  = 2'd1,
        SEL_INSVC = 2'd2,
        SEL_MODE  = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/irq_ext_pin.sv
// Capture stage for one active-low external interrupt pin.
// In edge mode a falling edge sets a sticky pending bit, and ack_clr clears it.
// In level mode the pending bit is the registered inverted pin.
// Assumes the pin is already synchronous to clk.
module irq_ext_pin (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic edge_mode,
    input  logic ack_clr,
    output logic pend
);

    logic prev_n;

    // Track the previous pin value and update the pending state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_n <= 1'b1;
            pend   <= 1'b0;
        end else begin
            prev_n <= pin_n;
            if (edge_mode) begin
                pend <= (pend | (prev_n & ~pin_n)) & ~ack_clr;
            end else begin
                pend <= ~pin_n;
            end
        end
    end

endmodule

// File: rtl/irq_int_pick.sv
// Selects the on-chip source to acknowledge.
// A source is eligible when it is pending and unmasked, and no in-service
// bit at its own index or above is set. The highest eligible index wins.
// Purely combinational.
module irq_int_pick #(
    parameter int N_SRC = 16,
    parameter int IDX_W = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0] pend,
    input  logic [N_SRC-1:0] mask,
    input  logic [N_SRC-1:0] insvc,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    logic [N_SRC-1:0] elig;

    // Block each source from its own in-service bit and all above it.
    always_comb begin
        logic blocked;
        blocked = 1'b0;
        for (int j = N_SRC - 1; j >= 0; j--) begin
            blocked = blocked | insvc[j];
            elig[j] = pend[j] & mask[j] & ~blocked;
        end
    end

    // Fixed priority encode: a later (higher) index overwrites an earlier one.
    always_comb begin
        idx = '0;
        for (int j = 0; j < N_SRC; j++) begin
            if (elig[j]) idx = IDX_W'(j);
        end
        any = |elig;
    end

endmodule

// File: rtl/irq_level_arb.sv
// Level arbitration between the on-chip group and the external pins.
// The highest level wins. At equal level an external pin beats the group,
// and a higher pin index beats a lower one. Also forms the source vector.
// Purely combinational.
module irq_level_arb #(
    parameter int                   N_INT     = 16,
    parameter int                   N_EXT     = 3,
    parameter int                   IDX_W     = 4,
    parameter int                   EXT_IDX_W = 2,
    parameter int                   LVL_W     = 3,
    parameter int                   VEC_W     = 8,
    parameter logic [LVL_W*N_EXT-1:0] EXT_LEVELS = '0,
    parameter int                   INT_LEVEL = 4,
    parameter int                   VEC_BASE  = 64
) (
    input  logic                 int_any,
    input  logic [IDX_W-1:0]     int_idx,
    input  logic [N_EXT-1:0]     ext_pend,
    output logic [LVL_W-1:0]     best_level,
    output logic                 best_ext,
    output logic [EXT_IDX_W-1:0] best_ext_idx,
    output logic [VEC_W-1:0]     best_vec
);

    // Start from the on-chip group, then let each pending pin take over on >=.
    always_comb begin
        best_level   = int_any ? LVL_W'(INT_LEVEL) : '0;
        best_ext     = 1'b0;
        best_ext_idx = '0;
        best_vec     = VEC_W'(VEC_BASE) + VEC_W'(int_idx);
        for (int k = 0; k < N_EXT; k++) begin
            if (ext_pend[k] && (EXT_LEVELS[k*LVL_W +: LVL_W] >= best_level)) begin
                best_level   = EXT_LEVELS[k*LVL_W +: LVL_W];
                best_ext     = 1'b1;
                best_ext_idx = EXT_IDX_W'(k);
                best_vec     = VEC_W'(VEC_BASE + N_INT + k);
            end
        end
    end

endmodule

// File: rtl/prio_irq_ctl.sv
// Prioritized interrupt controller: top level.
// Holds the mask, pending, in-service and mode registers, and takes an
// acknowledge at an instruction boundary when the winning level is above the
// core's run level. Assumes all inputs are synchronous to clk.
module prio_irq_ctl
    import irq_ctl_pkg::*;
#(
    parameter int                   N_INT      = 16,
    parameter int                   N_EXT      = 3,
    parameter int                   INT_LEVEL  = 4,
    parameter logic [3*N_EXT-1:0]   EXT_LEVELS = {3'd7, 3'd4, 3'd1},
    parameter int                   VEC_BASE   = 64,
    parameter int                   VEC_W      = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_INT-1:0]   int_req,
    input  logic [N_EXT-1:0]   ext_irq_n,
    input  logic [2:0]         run_level,
    input  logic               instr_end,
    input  logic [1:0]         reg_addr,
    input  logic               reg_wr,
    input  logic [N_INT-1:0]   reg_wdata,
    output logic [N_INT-1:0]   reg_rdata,
    output logic [2:0]         irq_level,
    output logic               ack_valid,
    output logic [VEC_W-1:0]   ack_vector,
    output logic [2:0]         ack_level
);

    localparam int IDX_W     = (N_INT > 1) ? $clog2(N_INT) : 1;
    localparam int EXT_IDX_W = (N_EXT > 1) ? $clog2(N_EXT) : 1;

    reg_sel_e sel;

    logic [N_INT-1:0] mask_q;
    logic [N_INT-1:0] pend_int_q;
    logic [N_INT-1:0] isvc_q;
    logic [N_EXT-1:0] mode_q;
    logic [N_EXT-1:0] ext_pend;
    logic [N_EXT-1:0] ext_clr;
    logic [N_INT-1:0] int_hit;
    logic [N_INT-1:0] isvc_wclr;

    logic                 int_any;
    logic [IDX_W-1:0]     int_idx;
    logic [LVL_W-1:0]     best_level;
    logic                 best_ext;
    logic [EXT_IDX_W-1:0] best_ext_idx;
    logic [VEC_W-1:0]     best_vec;
    logic                 qual;
    logic                 take;

    assign sel = reg_sel_e'(reg_addr);

    // One capture stage per external pin.
    generate
        for (genvar k = 0; k < N_EXT; k++) begin : g_pin
            irq_ext_pin u_pin (
                .clk       (clk),
                .rst_n     (rst_n),
                .pin_n     (ext_irq_n[k]),
                .edge_mode (mode_q[k]),
                .ack_clr   (ext_clr[k]),
                .pend      (ext_pend[k])
            );
        end
    endgenerate

    irq_int_pick #(
        .N_SRC (N_INT),
        .IDX_W (IDX_W)
    ) u_pick (
        .pend  (pend_int_q),
        .mask  (mask_q),
        .insvc (isvc_q),
        .any   (int_any),
        .idx   (int_idx)
    );

    irq_level_arb #(
        .N_INT      (N_INT),
        .N_EXT      (N_EXT),
        .IDX_W      (IDX_W),
        .EXT_IDX_W  (EXT_IDX_W),
        .LVL_W      (LVL_W),
        .VEC_W      (VEC_W),
        .EXT_LEVELS (EXT_LEVELS),
        .INT_LEVEL  (INT_LEVEL),
        .VEC_BASE   (VEC_BASE)
    ) u_arb (
        .int_any      (int_any),
        .int_idx      (int_idx),
        .ext_pend     (ext_pend),
        .best_level   (best_level),
        .best_ext     (best_ext),
        .best_ext_idx (best_ext_idx),
        .best_vec     (best_vec)
    );

    // Qualify the winner against the run level and decide whether to take it.
    always_comb begin
        qual      = best_level > run_level;
        take      = instr_end & qual;
        irq_level = qual ? best_level : '0;
    end

    // Turn a take into one-hot clear/set strobes for the chosen source.
    always_comb begin
        ext_clr = '0;
        int_hit = '0;
        if (take) begin
            if (best_ext) ext_clr[best_ext_idx] = 1'b1;
            else          int_hit[int_idx]      = 1'b1;
        end
        isvc_wclr = (reg_wr && sel == SEL_INSVC) ? reg_wdata : '0;
    end

    // Mask and mode registers: written by software only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            mode_q <= '0;
        end else if (reg_wr) begin
            if (sel == SEL_MASK) mask_q <= reg_wdata;
            if (sel == SEL_MODE) mode_q <= reg_wdata[N_EXT-1:0];
        end
    end

    // Pending and in-service: a request sets pending, an acknowledge moves it to in-service.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_int_q <= '0;
            isvc_q     <= '0;
        end else begin
            pend_int_q <= (pend_int_q | int_req) & ~int_hit;
            isvc_q     <= (isvc_q & ~isvc_wclr) | int_hit;
        end
    end

    // Acknowledge outputs: a one-cycle pulse carrying the winner's vector and level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_valid  <= 1'b0;
            ack_vector <= '0;
            ack_level  <= '0;
        end else begin
            ack_valid <= take;
            if (take) begin
                ack_vector <= best_vec;
                ack_level  <= best_level;
            end
        end
    end

    // Register read multiplexer.
    always_comb begin
        unique case (sel)
            SEL_MASK:  reg_rdata = mask_q;
            SEL_PEND:  reg_rdata = pend_int_q;
            SEL_INSVC: reg_rdata = isvc_q;
            default:   reg_rdata = N_INT'({ext_pend, mode_q});
        endcase
    end

endmodule

// Checker for prio_irq_ctl: the acknowledge timing and register side effects.
module irq_ctl_chk #(
    parameter int N_INT    = 16,
    parameter int VEC_BASE = 64,
    parameter int VEC_W    = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             instr_end,
    input logic [2:0]       run_level,
    input logic             ack_valid,
    input logic [VEC_W-1:0] ack_vector,
    input logic [2:0]       ack_level,
    input logic [N_INT-1:0] mask_q,
    input logic [N_INT-1:0] pend_int_q,
    input logic [N_INT-1:0] isvc_q
);

    localparam int IDX_W = (N_INT > 1) ? $clog2(N_INT) : 1;

    logic [VEC_W-1:0] off;
    logic             ack_int;
    logic [IDX_W-1:0] idx;
    logic [N_INT-1:0] mask_d;

    assign off     = ack_vector - VEC_W'(VEC_BASE);
    assign ack_int = ack_valid && (ack_vector >= VEC_W'(VEC_BASE)) && (off < VEC_W'(N_INT));
    assign idx     = off[IDX_W-1:0];

    // Previous-cycle copy of the mask register.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_d <= '0;
        else        mask_d <= mask_q;
    end

    a_r1_ack_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> $past(instr_end));

    a_r1_ack_above_run: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> (ack_level > $past(run_level)));

    a_r3_ack_was_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        ack_int |-> mask_d[idx]);

    a_r4_ack_clears_pending: assert property (@(posedge clk) disable iff (!rst_n)
        ack_int |-> !pend_int_q[idx]);

    a_r6_ack_sets_insvc: assert property (@(posedge clk) disable iff (!rst_n)
        ack_int |-> isvc_q[idx]);

endmodule

bind prio_irq_ctl irq_ctl_chk #(
    .N_INT    (N_INT),
    .VEC_BASE (VEC_BASE),
    .VEC_W    (VEC_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .instr_end  (instr_end),
    .run_level  (run_level),
    .ack_valid  (ack_valid),
    .ack_vector (ack_vector),
    .ack_level  (ack_level),
    .mask_q     (mask_q),
    .pend_int_q (pend_int_q),
    .isvc_q     (isvc_q)
);

// File: tb/test_prio_irq_ctl.sv
`timescale 1ns/100ps
module test_prio_irq_ctl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] int_req;
    logic [2:0]  ext_irq_n;
    logic [2:0]  run_level;
    logic        instr_end;
    logic [1:0]  reg_addr;
    logic        reg_wr;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata;
    logic [2:0]  irq_level;
    logic        ack_valid;
    logic [7:0]  ack_vector;
    logic [2:0]  ack_level;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    prio_irq_ctl i_prio_irq_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .int_req    (int_req),
        .ext_irq_n  (ext_irq_n),
        .run_level  (run_level),
        .instr_end  (instr_end),
        .reg_addr   (reg_addr),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq_level  (irq_level),
        .ack_valid  (ack_valid),
        .ack_vector (ack_vector),
        .ack_level  (ack_level)
    );

    typedef struct packed {
        logic [15:0] mask;
        logic [15:0] req;
        logic [2:0]  run;
        logic        ack;
        logic [7:0]  vec;
    } row_t;

    localparam int NROWS = 7;
    localparam row_t ROWS [NROWS] = '{
        '{16'hFFFF, 16'h0800, 3'd0, 1'b1, 8'h4B},
        '{16'hF7FF, 16'h0800, 3'd0, 1'b0, 8'h00},
        '{16'hFFFF, 16'h0005, 3'd0, 1'b1, 8'h42},
        '{16'hFFFB, 16'h0005, 3'd0, 1'b1, 8'h40},
        '{16'hFFFF, 16'h8001, 3'd3, 1'b1, 8'h4F},
        '{16'hFFFF, 16'h8001, 3'd4, 1'b0, 8'h00},
        '{16'h0400, 16'h0C00, 3'd0, 1'b1, 8'h4A}
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; int_req = '0; ext_irq_n = '1; run_level = '0;
        instr_end = 1'b0; reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0;
        step(); step();
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        reg_addr = a;
        #0.2;
        d = reg_rdata;
    endtask

    task automatic pulse_req(input logic [15:0] m);
        int_req = m;
        step();
        int_req = '0;
    endtask

    task automatic boundary();
        instr_end = 1'b1;
        step();
        instr_end = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;

        // Table: R1, R2, R3, R5, R11 arbitration over mask, requests and run level.
        for (int i = 0; i < NROWS; i++) begin
            do_reset();
            wr(2'd0, ROWS[i].mask);
            run_level = ROWS[i].run;
            pulse_req(ROWS[i].req);
            boundary();
            check($sformatf("R1 R3 R5 R11 row %0d ack", i), ack_valid, ROWS[i].ack);
            if (ROWS[i].ack) check($sformatf("R5 R11 row %0d vector", i), ack_vector, ROWS[i].vec);
        end

        // R12: reset state.
        do_reset();
        rd(2'd0, d); check("R12 mask", d, 0);
        rd(2'd1, d); check("R12 pend", d, 0);
        rd(2'd2, d); check("R12 insvc", d, 0);
        rd(2'd3, d); check("R12 mode", d, 0);
        check("R12 irq_level", irq_level, 0);
        check("R12 ack", ack_valid, 0);

        // R3/R4: masked request is still recorded but not presented.
        pulse_req(16'h0008);
        rd(2'd1, d); check("R4 pend recorded", d, 16'h0008);
        check("R3 masked level", irq_level, 0);
        boundary();
        check("R3 masked no ack", ack_valid, 0);

        // R2/R1: enabled source presents level 4 and waits for the boundary.
        wr(2'd0, 16'hFFFF);
        check("R2 level", irq_level, 4);
        step(); step();
        check("R1 no boundary no ack", ack_valid, 0);
        boundary();
        check("R1 ack", ack_valid, 1);
        check("R5 vector", ack_vector, 8'h43);
        check("R2 ack level", ack_level, 4);
        rd(2'd1, d); check("R4 pend cleared", d, 0);
        rd(2'd2, d); check("R6 insvc set", d, 16'h0008);
        step();
        check("R1 single pulse", ack_valid, 0);

        // R6: lower source blocked, higher source still served.
        pulse_req(16'h0002);
        check("R6 lower blocked level", irq_level, 0);
        boundary();
        check("R6 lower blocked ack", ack_valid, 0);
        pulse_req(16'h0200);
        boundary();
        check("R6 higher ack", ack_valid, 1);
        check("R6 higher vector", ack_vector, 8'h49);
        rd(2'd2, d); check("R6 insvc both", d, 16'h0208);

        // R7: write-one-to-clear in-service.
        wr(2'd2, 16'h0000);
        rd(2'd2, d); check("R7 zero write no effect", d, 16'h0208);
        wr(2'd2, 16'h0200);
        rd(2'd2, d); check("R7 clear one bit", d, 16'h0008);
        check("R7 still blocked", irq_level, 0);
        wr(2'd2, 16'h0008);
        check("R7 unblocked level", irq_level, 4);
        boundary();
        check("R7 lower now acked", ack_vector, 8'h41);

        // R6/R7 same edge: acknowledge bit 11 while clearing bits 1 and 11.
        pulse_req(16'h0800);
        reg_addr = 2'd2; reg_wdata = 16'h0802; reg_wr = 1'b1; instr_end = 1'b1;
        step();
        reg_wr = 1'b0; instr_end = 1'b0;
        check("R11 dma ack vector", ack_vector, 8'h4B);
        rd(2'd2, d); check("R7 set wins over clear", d, 16'h0800);

        // R8: edge-mode pin 2 at level 7.
        do_reset();
        wr(2'd3, 16'h0007);
        ext_irq_n = 3'b011;
        step();
        rd(2'd3, d); check("R8 edge pending", d, 16'h0027);
        check("R10 level 7", irq_level, 7);
        run_level = 3'd7;
        boundary();
        check("R1 not above run", ack_valid, 0);
        run_level = 3'd6;
        boundary();
        check("R8 ack", ack_valid, 1);
        check("R8 vector", ack_vector, 8'h52);
        check("R8 level", ack_level, 7);
        step();
        rd(2'd3, d); check("R8 cleared held low", d, 16'h0007);
        ext_irq_n = 3'b111;

        // R9/R10: level-mode pin 1 ties with on-chip level 4.
        run_level = 3'd0;
        wr(2'd0, 16'hFFFF);
        wr(2'd3, 16'h0000);
        ext_irq_n = 3'b101;
        pulse_req(16'h0001);
        boundary();
        check("R10 tie external wins", ack_vector, 8'h51);
        check("R10 tie level", ack_level, 4);
        rd(2'd3, d); check("R9 level stays pending", d, 16'h0010);
        ext_irq_n = 3'b111;
        step();
        rd(2'd3, d); check("R9 follows pin", d, 16'h0000);
        boundary();
        check("R10 internal after", ack_vector, 8'h40);

        // R10: low-level pin loses to on-chip group, then is served.
        wr(2'd2, 16'h0001);
        wr(2'd3, 16'h0001);
        ext_irq_n = 3'b110;
        pulse_req(16'h0004);
        ext_irq_n = 3'b111;
        boundary();
        check("R10 higher level first", ack_vector, 8'h42);
        check("R10 pin level shown", irq_level, 1);
        boundary();
        check("R10 pin served", ack_vector, 8'h50);
        check("R10 pin ack level", ack_level, 1);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule